// File: doc/BRIEF.md
# Stream-to-VGA Video Bridge

This block sits between a pixel stream from a frame-buffer reader and a VGA connector. It owns the display raster. An internal counter pair walks a fixed 2200 x 1125 clock grid, which gives 1080p at 60 frames per second on a 148.5 MHz pixel clock. From that grid it derives horizontal sync, vertical sync and an active-video flag. During each active pixel it takes one 24-bit RGB beat from an AXI4-Stream slave port and drives the upper four bits of each colour channel to the pins.

The stream is aligned to the raster before any picture is shown. The start-of-frame marker (tuser) must land on the first active pixel. After that, every end-of-line marker (tlast) must land on the last active column. While the block is out of alignment it drains stream beats. If an end-of-line marker arrives at the wrong place, it drops alignment and records a sticky error. A missing beat during an active pixel shows black and records a sticky underflow.

The raster sizes are parameters, so a small raster can be used for quick simulation.

Top module: `axis_vga_bridge`

## Requirements
- R1: Each line is HACT+HFP+HSW+HBP clocks and each frame is VACT+VFP+VSW+VBP lines. The active region is the first HACT clocks of each of the first VACT lines. vga_de is high exactly there, one clock after the raster position, because all VGA outputs are registered.
- R2: vga_hs is high for HSW clocks starting HACT+HFP clocks into each line. vga_vs is high for whole lines, VSW of them, starting at line VACT+VFP. Both are active high.
- R3: vga_r, vga_g and vga_b are zero whenever vga_de is low.
- R4: A displayed beat drives the following outputs:
  - vga_r = s_tdata[23:20] (red occupies bits 23:16)
  - vga_g = s_tdata[15:12] (green occupies bits 15:8)
  - vga_b = s_tdata[7:4] (blue occupies bits 7:0)
- R5: While aligned, s_tready is high exactly on active pixels. Each accepted beat is shown on the next clock.
- R6: While not aligned, beats without tuser are accepted and discarded, and black is shown. A beat with tuser is held (s_tready low) until the first active pixel of a frame. It is then accepted and shown, and alignment is gained.
- R7: While aligned, an accepted beat with tlast at any column other than HACT-1 drops alignment from the next clock. It also sets sync_err, which stays set until reset.
- R8: While aligned, an active pixel with s_tvalid low shows black, consumes no beat, and sets underflow, which stays set until reset.
- R9: With clk_en low, the raster position, the outputs and the flags all hold, and s_tready is low.
- R10: While rst_n is low, the following hold:
  - all outputs and flags are zero;
  - alignment is cleared;
  - the raster restarts at the first active pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Advance enable; tie high for continuous run |
| s_tdata | input | 3*CH_IN | Pixel, red in the top byte, blue in the bottom byte |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tuser | input | 1 | Start-of-frame marker |
| s_tlast | input | 1 | End-of-line marker |
| vga_r | output | CH_OUT | Red |
| vga_g | output | CH_OUT | Green |
| vga_b | output | CH_OUT | Blue |
| vga_hs | output | 1 | Horizontal sync, active high |
| vga_vs | output | 1 | Vertical sync, active high |
| vga_de | output | 1 | Active video |
| sync_err | output | 1 | Sticky misplaced end-of-line |
| underflow | output | 1 | Sticky missing beat |

## Verification
A wrong raster count shows up as misplaced sync or active-video edges within one line. A wrong vertical count shows up within one frame. A wrong alignment state shows on the very next clock: s_tready either opens during blanking or stays shut on an active pixel, and the colour pins then show black where a pixel belongs, or the reverse. A lost flag update shows as a sticky output that never rises, or one that falls without a reset.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
    typedef enum logic {
        ALIGN_HUNT = 1'b0,
        ALIGN_RUN  = 1'b1
    } align_e;

    localparam int unsigned RGB_CHANNELS = 3;
endpackage

// File: rtl/vbr_timing.sv
module vbr_timing #(
    parameter int unsigned HACT = 1920,
    parameter int unsigned HFP  = 88,
    parameter int unsigned HSW  = 44,
    parameter int unsigned HBP  = 148,
    parameter int unsigned VACT = 1080,
    parameter int unsigned VFP  = 4,
    parameter int unsigned VSW  = 5,
    parameter int unsigned VBP  = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic active,
    output logic first_px,
    output logic last_col,
    output logic hsync,
    output logic vsync
);
    localparam int unsigned HTOT = HACT + HFP + HSW + HBP;
    localparam int unsigned VTOT = VACT + VFP + VSW + VBP;
    localparam int unsigned HW   = $clog2(HTOT);
    localparam int unsigned VW   = $clog2(VTOT);

    typedef struct packed {
        logic [HW-1:0] col;
        logic [VW-1:0] row;
    } raster_t;

    raster_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (en) begin
            if (pos_q.col == HW'(HTOT - 1)) begin
                pos_d.col = '0;
                if (pos_q.row == VW'(VTOT - 1)) begin
                    pos_d.row = '0;
                end else begin
                    pos_d.row = pos_q.row + 1'b1;
                end
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign active   = (pos_q.col < HW'(HACT)) && (pos_q.row < VW'(VACT));
    assign first_px = (pos_q.col == '0) && (pos_q.row == '0);
    assign last_col = (pos_q.col == HW'(HACT - 1));
    assign hsync    = (pos_q.col >= HW'(HACT + HFP)) && (pos_q.col < HW'(HACT + HFP + HSW));
    assign vsync    = (pos_q.row >= VW'(VACT + VFP)) && (pos_q.row < VW'(VACT + VFP + VSW));
endmodule

// File: rtl/vbr_align.sv
module vbr_align
    import vbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic active,
    input  logic first_px,
    input  logic last_col,
    input  logic s_tvalid,
    input  logic s_tuser,
    input  logic s_tlast,
    output logic s_tready,
    output logic show_beat,
    output logic aligned,
    output logic sync_err,
    output logic underflow
);
    typedef struct packed {
        align_e mode;
        logic   err;
        logic   und;
    } align_t;

    align_t st_d, st_q;
    logic   accept;
    logic   gain;

    always_comb begin
        if (st_q.mode == ALIGN_RUN) begin
            s_tready = en && active;
        end else begin
            s_tready = en && (!s_tuser || first_px);
        end
        accept    = s_tready && s_tvalid;
        gain      = (st_q.mode == ALIGN_HUNT) && accept && s_tuser && first_px;
        show_beat = accept && ((st_q.mode == ALIGN_RUN) || gain);

        st_d = st_q;
        if (en) begin
            if (st_q.mode == ALIGN_RUN) begin
                if (active && !s_tvalid) begin
                    st_d.und = 1'b1;
                end
                if (accept && s_tlast && !last_col) begin
                    st_d.err  = 1'b1;
                    st_d.mode = ALIGN_HUNT;
                end
            end else if (gain) begin
                st_d.mode = ALIGN_RUN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: ALIGN_HUNT, err: 1'b0, und: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign aligned   = (st_q.mode == ALIGN_RUN);
    assign sync_err  = st_q.err;
    assign underflow = st_q.und;
endmodule

// File: rtl/vbr_pixout.sv
module vbr_pixout
    import vbr_pkg::*;
#(
    parameter int unsigned CH_IN  = 8,
    parameter int unsigned CH_OUT = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               en,
    input  logic                               active,
    input  logic                               hsync,
    input  logic                               vsync,
    input  logic                               show_beat,
    input  logic [RGB_CHANNELS*CH_IN-1:0]      pix_in,
    output logic                               de_o,
    output logic                               hs_o,
    output logic                               vs_o,
    output logic [RGB_CHANNELS*CH_OUT-1:0]     rgb_o
);
    localparam int unsigned DROP = CH_IN - CH_OUT;

    typedef struct packed {
        logic                           de;
        logic                           hs;
        logic                           vs;
        logic [RGB_CHANNELS*CH_OUT-1:0] rgb;
    } vout_t;

    vout_t out_d, out_q;
    logic [RGB_CHANNELS*CH_OUT-1:0] narrow;

    for (genvar ch = 0; ch < RGB_CHANNELS; ch++) begin : g_chan
        assign narrow[ch*CH_OUT +: CH_OUT] = pix_in[ch*CH_IN + DROP +: CH_OUT];
    end

    always_comb begin
        out_d = out_q;
        if (en) begin
            out_d.de  = active;
            out_d.hs  = hsync;
            out_d.vs  = vsync;
            out_d.rgb = show_beat ? narrow : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign de_o  = out_q.de;
    assign hs_o  = out_q.hs;
    assign vs_o  = out_q.vs;
    assign rgb_o = out_q.rgb;
endmodule

// File: rtl/axis_vga_bridge.sv
module axis_vga_bridge
    import vbr_pkg::*;
#(
    parameter int unsigned HACT   = 1920,
    parameter int unsigned HFP    = 88,
    parameter int unsigned HSW    = 44,
    parameter int unsigned HBP    = 148,
    parameter int unsigned VACT   = 1080,
    parameter int unsigned VFP    = 4,
    parameter int unsigned VSW    = 5,
    parameter int unsigned VBP    = 36,
    parameter int unsigned CH_IN  = 8,
    parameter int unsigned CH_OUT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic [3*CH_IN-1:0]      s_tdata,
    input  logic                    s_tvalid,
    output logic                    s_tready,
    input  logic                    s_tuser,
    input  logic                    s_tlast,
    output logic [CH_OUT-1:0]       vga_r,
    output logic [CH_OUT-1:0]       vga_g,
    output logic [CH_OUT-1:0]       vga_b,
    output logic                    vga_hs,
    output logic                    vga_vs,
    output logic                    vga_de,
    output logic                    sync_err,
    output logic                    underflow
);
    logic act, first_px, last_col, hs_raw, vs_raw;
    logic show_beat, aligned;
    logic [RGB_CHANNELS*CH_OUT-1:0] rgb;

    vbr_timing #(
        .HACT(HACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
        .VACT(VACT), .VFP(VFP), .VSW(VSW), .VBP(VBP)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_en),
        .active   (act),
        .first_px (first_px),
        .last_col (last_col),
        .hsync    (hs_raw),
        .vsync    (vs_raw)
    );

    vbr_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .active    (act),
        .first_px  (first_px),
        .last_col  (last_col),
        .s_tvalid  (s_tvalid),
        .s_tuser   (s_tuser),
        .s_tlast   (s_tlast),
        .s_tready  (s_tready),
        .show_beat (show_beat),
        .aligned   (aligned),
        .sync_err  (sync_err),
        .underflow (underflow)
    );

    vbr_pixout #(.CH_IN(CH_IN), .CH_OUT(CH_OUT)) u_pixout (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clk_en),
        .active    (act),
        .hsync     (hs_raw),
        .vsync     (vs_raw),
        .show_beat (show_beat),
        .pix_in    (s_tdata),
        .de_o      (vga_de),
        .hs_o      (vga_hs),
        .vs_o      (vga_vs),
        .rgb_o     (rgb)
    );

    assign vga_r = rgb[2*CH_OUT +: CH_OUT];
    assign vga_g = rgb[CH_OUT +: CH_OUT];
    assign vga_b = rgb[0 +: CH_OUT];
endmodule

// File: rtl/vbr_checks.sv
module vbr_checks #(
    parameter int unsigned CO = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          s_tready,
    input logic          aligned,
    input logic          vga_de,
    input logic          vga_hs,
    input logic          vga_vs,
    input logic [CO-1:0] vga_r,
    input logic [CO-1:0] vga_g,
    input logic [CO-1:0] vga_b,
    input logic          sync_err,
    input logic          underflow
);
    assert_blank_black_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vga_de |-> ({vga_r, vga_g, vga_b} == '0));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);

    assert_und_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    assert_ready_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> clk_en);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable({vga_de, vga_hs, vga_vs, vga_r, vga_g, vga_b, sync_err, underflow}));

    assert_ready_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && s_tready) |=> vga_de);
endmodule

bind axis_vga_bridge vbr_checks #(.CO(CH_OUT)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .s_tready  (s_tready),
    .aligned   (aligned),
    .vga_de    (vga_de),
    .vga_hs    (vga_hs),
    .vga_vs    (vga_vs),
    .vga_r     (vga_r),
    .vga_g     (vga_g),
    .vga_b     (vga_b),
    .sync_err  (sync_err),
    .underflow (underflow)
);

// File: tb/axis_vga_bridge_tb.sv
module axis_vga_bridge_tb;
    localparam int HACT = 8, HFP = 2, HSW = 3, HBP = 3;
    localparam int VACT = 4, VFP = 1, VSW = 2, VBP = 2;
    localparam int HTOT = HACT + HFP + HSW + HBP;
    localparam int VTOT = VACT + VFP + VSW + VBP;
    localparam int FRAME_PIX = HACT * VACT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic [23:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic        s_tuser = 1'b0;
    logic        s_tlast = 1'b0;
    logic [3:0]  vga_r, vga_g, vga_b;
    logic        vga_hs, vga_vs, vga_de, sync_err, underflow;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    int mh, mv;
    bit mlock, merr, mund;
    bit e_de, e_hs, e_vs;
    logic [11:0] e_rgb;
    // source state
    int sidx;
    logic [23:0] sdata;
    bit sbad, svalid;

    always #10 clk = ~clk;

    axis_vga_bridge #(
        .HACT(HACT), .HFP(HFP), .HSW(HSW), .HBP(HBP),
        .VACT(VACT), .VFP(VFP), .VSW(VSW), .VBP(VBP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tuser(s_tuser), .s_tlast(s_tlast),
        .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b),
        .vga_hs(vga_hs), .vga_vs(vga_vs), .vga_de(vga_de),
        .sync_err(sync_err), .underflow(underflow)
    );

    function automatic logic [11:0] narrow(input logic [23:0] d);
        return {d[23:20], d[15:12], d[7:4]};
    endfunction

    function automatic bit in_hsync(input int h);
        return (h >= HACT + HFP) && (h < HACT + HFP + HSW);
    endfunction

    function automatic bit in_vsync(input int v);
        return (v >= VACT + VFP) && (v < VACT + VFP + VSW);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic new_beat(input int pbad);
        sdata  = 24'($urandom);
        sbad   = ($urandom_range(999) < pbad);
        svalid = 1'b0;
    endtask

    task automatic do_reset(input int start_idx);
        @(negedge clk);
        rst_n = 1'b0;
        clk_en = 1'b0;
        s_tvalid = 1'b0;
        repeat (2) @(negedge clk);
        // R10: outputs and flags cleared during reset
        check({vga_de, vga_hs, vga_vs} == 3'b000, "R10 sync/de", {vga_de, vga_hs, vga_vs}, 0);
        check({vga_r, vga_g, vga_b} == 12'h0, "R10 colour", {vga_r, vga_g, vga_b}, 0);
        check({sync_err, underflow} == 2'b00, "R10 flags", {sync_err, underflow}, 0);
        rst_n = 1'b1;
        mh = 0; mv = 0; mlock = 0; merr = 0; mund = 0;
        e_de = 0; e_hs = 0; e_vs = 0; e_rgb = '0;
        sidx = start_idx;
        new_beat(0);
    endtask

    task automatic run_phase(input int cycles, input int pvalid, input int pbad, input int pen);
        for (int c = 0; c < cycles; c++) begin
            bit act, first, lastc, rdy, acc, take, en;
            @(negedge clk);
            check(vga_de == e_de, "R1 de", vga_de, e_de);
            check(vga_hs == e_hs, "R2 hsync", vga_hs, e_hs);
            check(vga_vs == e_vs, "R2 vsync", vga_vs, e_vs);
            check({vga_r, vga_g, vga_b} == e_rgb, "R4 colour", {vga_r, vga_g, vga_b}, e_rgb);
            check(sync_err == merr, "R7 sync_err", sync_err, merr);
            check(underflow == mund, "R8 underflow", underflow, mund);
            if (!svalid) svalid = ($urandom_range(99) < pvalid);
            en = ($urandom_range(99) < pen);
            clk_en   = en;
            s_tvalid = svalid;
            s_tdata  = sdata;
            s_tuser  = (sidx == 0);
            s_tlast  = ((sidx % HACT) == HACT - 1) ^ sbad;
            #1;
            act   = (mh < HACT) && (mv < VACT);
            first = (mh == 0) && (mv == 0);
            lastc = (mh == HACT - 1);
            if (mlock) rdy = en && act;
            else       rdy = en && (!s_tuser || first);
            acc  = rdy && svalid;
            take = acc && (mlock || (s_tuser && first));
            if (mlock) check(s_tready == rdy, "R5 ready aligned", s_tready, rdy);
            else       check(s_tready == rdy, "R6 ready hunting", s_tready, rdy);
            if (en) begin
                e_de  = act;
                e_hs  = in_hsync(mh);
                e_vs  = in_vsync(mv);
                e_rgb = take ? narrow(sdata) : 12'h0;
                if (mlock) begin
                    if (act && !svalid) mund = 1;
                    if (acc && s_tlast && !lastc) begin
                        merr = 1;
                        mlock = 0;
                    end
                end else if (take) begin
                    mlock = 1;
                end
                if (mh == HTOT - 1) begin
                    mh = 0;
                    mv = (mv == VTOT - 1) ? 0 : mv + 1;
                end else begin
                    mh = mh + 1;
                end
            end
            if (acc) begin
                sidx = (sidx + 1) % FRAME_PIX;
                new_beat(pbad);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        // clean stream with junk prefix: R1 R2 R4 R5 R6
        do_reset(5);
        run_phase(6 * HTOT * VTOT, 100, 0, 100);
        check(sync_err == 1'b0, "R7 clean run no error", sync_err, 0);
        check(underflow == 1'b0, "R8 clean run no underflow", underflow, 0);
        // starved stream: R8
        do_reset(0);
        run_phase(6 * HTOT * VTOT, 80, 0, 100);
        check(underflow == 1'b1, "R8 starved stream flags", underflow, 1);
        // random enable: R9
        do_reset(17);
        run_phase(8 * HTOT * VTOT, 100, 0, 60);
        check(sync_err == 1'b0, "R9 gated run no error", sync_err, 0);
        // misplaced tlast: R7 with realignment
        do_reset(0);
        run_phase(8 * HTOT * VTOT, 100, 50, 100);
        check(sync_err == 1'b1, "R7 misplaced tlast flags", sync_err, 1);
        // everything mixed
        do_reset(3);
        run_phase(10 * HTOT * VTOT, 90, 10, 85);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule